// File: doc/BRIEF.md
# DMA Transfer Unit Bus-Cycle Sequencer

This block carries a single transfer unit, either one byte or one 16-bit halfword, from a source address to a destination address over a simple synchronous bus. A start pulse latches the request. The block then runs the source read accesses and, after them, the destination write accesses. It gathers the unit in an internal buffer between the two phases and gives a one-clock done pulse when the unit is finished.

Each phase is planned on its own. The planner counts the accesses a phase needs from four things: the unit size, the external bus width selector, the low address bit, and whether the phase start address falls into one of two programmable windows (a register window and a slow-memory window). A phase that targets either window stretches each of its accesses by one clock. The block also reports the bus cycles of each phase and a weighted total for the unit, using two programmable coefficients. Channel selection, request sources, address stepping and transfer counting belong to the surrounding controller.

Top module: `dma_unit_seq`

## Requirements
- R1: A start pulse seen while idle begins a unit, and busy is high from the next clock. All source reads are issued before any destination write. A start pulse seen while busy changes neither the accesses in progress nor the reported counts, and it does not launch a second unit.
- R2: A 16-bit unit at an even address on the 16-bit bus (width select low) uses one word access with byte enables 2'b11.
- R3: A 16-bit unit at an odd address on the 16-bit bus uses two byte accesses. The first is at the address itself on the upper lane (byte enables 2'b10). The second is at the address plus one on the lower lane (2'b01). The lower-addressed byte is always the low byte of the unit.
- R4: With width select high (8-bit bus), a 16-bit unit uses two byte accesses on the lower lane (2'b01), first at the address and then at the address plus one, for either alignment.
- R5: An 8-bit unit uses exactly one byte access per phase. On the 16-bit bus its lane follows address bit 0 (2'b10 when odd, 2'b01 when even). On the 8-bit bus it always uses the lower lane.
- R6: A phase whose start address lies inside [reg_base, reg_limit] or inside [wait_base, wait_limit] (both bounds inclusive) stretches every access of that phase. The first clock of each such access never completes.
- R7: An access completes only on a clock where bus_ready_i is high, at or after its stretch clock. While it waits, request, address, byte enables and direction stay steady.
- R8: The bytes read are written unchanged, each on its addressed lane. Once the unit is finished, data_o holds the unit, with the upper byte zero for an 8-bit unit.
- R9: From the clock after an accepted start, rd_cycles_o and wr_cycles_o show accesses × (1 + stretch) for each phase. The possible values are 1, 2 and 4.
- R10: total_cycles_o equals rd_cycles_o × coef_rd_i + wr_cycles_o × coef_wr_i, with both coefficients sampled at the accepted start. The output is 8 bits wide, so the worst case of 120 does not overflow.
- R11: done_o is high for exactly one clock. That clock is the first one after the final write access completes, and busy_o is low in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a unit (one-clock pulse) |
| unit16_i | input | 1 | 1: 16-bit unit, 0: 8-bit unit |
| bus8_i | input | 1 | 1: 8-bit external bus, 0: 16-bit bus |
| src_addr_i | input | AW | Source byte address |
| dst_addr_i | input | AW | Destination byte address |
| reg_base_i | input | AW | Register window lower bound |
| reg_limit_i | input | AW | Register window upper bound |
| wait_base_i | input | AW | Slow window lower bound |
| wait_limit_i | input | AW | Slow window upper bound |
| coef_rd_i | input | CW | Read weighting coefficient |
| coef_wr_i | input | CW | Write weighting coefficient |
| bus_ready_i | input | 1 | Bus ready for the current access |
| bus_rdata_i | input | 16 | Read data lanes |
| busy_o | output | 1 | Unit in progress |
| done_o | output | 1 | One-clock completion pulse |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | 1: write, 0: read |
| bus_addr_o | output | AW | Access byte address |
| bus_be_o | output | 2 | Byte-lane enables |
| bus_wdata_o | output | 16 | Write data lanes |
| data_o | output | 16 | Unit buffer |
| rd_cycles_o | output | 3 | Read-phase bus cycles |
| wr_cycles_o | output | 3 | Write-phase bus cycles |
| total_cycles_o | output | CW+4 | Weighted cycles for the unit |

## Verification
A wrong access index or lane decision shows up at the very next access. The address or byte enables differ from the expected ones in the same clock they are driven, and a byte lost in assembly becomes wrong write data one phase later. A broken stretch or ready path makes an access end one clock early or late, which the bench sees at the following clock edge as a changed or unchanged request. Plan errors appear in the cycle counts the clock after start, and a lost completion appears as a missing or doubled done pulse right after the final write.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int BYTE_W   = 8;
  localparam int UNIT_W   = 2 * BYTE_W;
  localparam int LANES    = UNIT_W / BYTE_W;
  localparam int PH_CNT_W = 3;
  localparam int NWIN     = 2;

  typedef struct packed {
    logic                split;
    logic                word;
    logic                ext;
    logic [PH_CNT_W-1:0] cycles;
  } phase_plan_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dma_region_cmp.sv
module dma_region_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic          hit_o
);

  always_comb begin
    hit_o = (addr_i >= lo_i) && (addr_i <= hi_i);
  end

endmodule

// File: rtl/dma_phase_plan.sv
module dma_phase_plan
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]           addr_i,
  input  logic                    unit16_i,
  input  logic                    bus8_i,
  input  logic [NWIN-1:0][AW-1:0] win_lo_i,
  input  logic [NWIN-1:0][AW-1:0] win_hi_i,
  output phase_plan_t             plan_o
);

  logic [NWIN-1:0] win_hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    dma_region_cmp #(.AW(AW)) u_cmp (
      .addr_i (addr_i),
      .lo_i   (win_lo_i[w]),
      .hi_i   (win_hi_i[w]),
      .hit_o  (win_hit[w])
    );
  end

  logic                split;
  logic [PH_CNT_W-1:0] n_acc;

  always_comb begin
    split         = unit16_i & (bus8_i | addr_i[0]);
    n_acc         = split ? PH_CNT_W'(2) : PH_CNT_W'(1);
    plan_o.split  = split;
    plan_o.word   = unit16_i & ~split;
    plan_o.ext    = |win_hit;
    plan_o.cycles = plan_o.ext ? (n_acc << 1) : n_acc;
  end

endmodule

// File: rtl/dma_bus_engine.sv
module dma_bus_engine
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              bus8_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  phase_plan_t       plan_rd_i,
  input  phase_plan_t       plan_wr_i,
  input  logic              ready_i,
  input  logic [UNIT_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [UNIT_W-1:0] wdata_o,
  output logic [UNIT_W-1:0] data_o
);

  seq_state_e        state_q, state_n;
  logic              idx_q, idx_n;
  logic              elapsed_q, elapsed_n;
  logic              done_q, done_n;
  logic [UNIT_W-1:0] buf_q, buf_n;

  phase_plan_t       cur;
  logic [AW-1:0]     base;
  logic              lane_hi;
  logic              fin;
  logic              last;
  logic [BYTE_W-1:0] rbyte;
  logic [BYTE_W-1:0] wbyte;

  always_comb begin
    cur     = (state_q == ST_WR) ? plan_wr_i : plan_rd_i;
    base    = (state_q == ST_WR) ? dst_i : src_i;
    addr_o  = base + AW'(idx_q);
    lane_hi = ~bus8_i & addr_o[0];
    req_o   = (state_q != ST_IDLE);
    we_o    = (state_q == ST_WR);
    busy_o  = req_o;
    if (cur.word) be_o = 2'b11;
    else          be_o = lane_hi ? 2'b10 : 2'b01;
    fin     = req_o & ready_i & (elapsed_q | ~cur.ext);
    last    = ~cur.split | idx_q;
    rbyte   = lane_hi ? rdata_i[UNIT_W-1:BYTE_W] : rdata_i[BYTE_W-1:0];
    wbyte   = idx_q ? buf_q[UNIT_W-1:BYTE_W] : buf_q[BYTE_W-1:0];
    if (cur.word)     wdata_o = buf_q;
    else if (lane_hi) wdata_o = {wbyte, {BYTE_W{1'b0}}};
    else              wdata_o = {{BYTE_W{1'b0}}, wbyte};
    done_o  = done_q;
    data_o  = buf_q;
  end

  always_comb begin
    state_n   = state_q;
    idx_n     = idx_q;
    elapsed_n = elapsed_q;
    buf_n     = buf_q;
    done_n    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          state_n   = ST_RD;
          idx_n     = 1'b0;
          elapsed_n = 1'b0;
          buf_n     = '0;
        end
      end
      ST_RD: begin
        if (fin) begin
          elapsed_n = 1'b0;
          if (cur.word)   buf_n = rdata_i;
          else if (idx_q) buf_n[UNIT_W-1:BYTE_W] = rbyte;
          else            buf_n[BYTE_W-1:0] = rbyte;
          if (last) begin
            state_n = ST_WR;
            idx_n   = 1'b0;
          end else begin
            idx_n = 1'b1;
          end
        end else begin
          elapsed_n = 1'b1;
        end
      end
      ST_WR: begin
        if (fin) begin
          elapsed_n = 1'b0;
          if (last) begin
            state_n = ST_IDLE;
            idx_n   = 1'b0;
            done_n  = 1'b1;
          end else begin
            idx_n = 1'b1;
          end
        end else begin
          elapsed_n = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= 1'b0;
      elapsed_q <= 1'b0;
      done_q    <= 1'b0;
      buf_q     <= '0;
    end else begin
      state_q   <= state_n;
      idx_q     <= idx_n;
      elapsed_q <= elapsed_n;
      done_q    <= done_n;
      buf_q     <= buf_n;
    end
  end

endmodule

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/dma_unit_seq.sv
module dma_unit_seq
  import dma_seq_pkg::*;
#(
  parameter  int AW    = 16,
  parameter  int CW    = 4,
  localparam int TOT_W = PH_CNT_W + CW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                unit16_i,
  input  logic                bus8_i,
  input  logic [AW-1:0]       src_addr_i,
  input  logic [AW-1:0]       dst_addr_i,
  input  logic [AW-1:0]       reg_base_i,
  input  logic [AW-1:0]       reg_limit_i,
  input  logic [AW-1:0]       wait_base_i,
  input  logic [AW-1:0]       wait_limit_i,
  input  logic [CW-1:0]       coef_rd_i,
  input  logic [CW-1:0]       coef_wr_i,
  input  logic                bus_ready_i,
  input  logic [UNIT_W-1:0]   bus_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [AW-1:0]       bus_addr_o,
  output logic [LANES-1:0]    bus_be_o,
  output logic [UNIT_W-1:0]   bus_wdata_o,
  output logic [UNIT_W-1:0]   data_o,
  output logic [PH_CNT_W-1:0] rd_cycles_o,
  output logic [PH_CNT_W-1:0] wr_cycles_o,
  output logic [TOT_W-1:0]    total_cycles_o
);

  logic rst_s_n;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_s_n)
  );

  // Planning for both phases from the live request
  logic [NWIN-1:0][AW-1:0] win_lo, win_hi;
  logic [1:0][AW-1:0]      ph_addr;
  phase_plan_t             ph_plan [2];

  always_comb begin
    win_lo     = {wait_base_i, reg_base_i};
    win_hi     = {wait_limit_i, reg_limit_i};
    ph_addr[0] = src_addr_i;
    ph_addr[1] = dst_addr_i;
  end

  for (genvar p = 0; p < 2; p++) begin : g_phase
    dma_phase_plan #(.AW(AW)) u_plan (
      .addr_i   (ph_addr[p]),
      .unit16_i (unit16_i),
      .bus8_i   (bus8_i),
      .win_lo_i (win_lo),
      .win_hi_i (win_hi),
      .plan_o   (ph_plan[p])
    );
  end

  logic             accept;
  logic [TOT_W-1:0] total_n;

  always_comb begin
    accept  = start_i & ~busy_o;
    total_n = TOT_W'(ph_plan[0].cycles) * TOT_W'(coef_rd_i)
            + TOT_W'(ph_plan[1].cycles) * TOT_W'(coef_wr_i);
  end

  // Request registers, loaded only when a start is accepted
  logic [AW-1:0]    src_q, dst_q;
  logic             bus8_q;
  phase_plan_t      plan_rd_q, plan_wr_q;
  logic [TOT_W-1:0] total_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      src_q     <= '0;
      dst_q     <= '0;
      bus8_q    <= 1'b0;
      plan_rd_q <= '0;
      plan_wr_q <= '0;
      total_q   <= '0;
    end else if (accept) begin
      src_q     <= src_addr_i;
      dst_q     <= dst_addr_i;
      bus8_q    <= bus8_i;
      plan_rd_q <= ph_plan[0];
      plan_wr_q <= ph_plan[1];
      total_q   <= total_n;
    end
  end

  dma_bus_engine #(.AW(AW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .go_i      (accept),
    .bus8_i    (bus8_q),
    .src_i     (src_q),
    .dst_i     (dst_q),
    .plan_rd_i (plan_rd_q),
    .plan_wr_i (plan_wr_q),
    .ready_i   (bus_ready_i),
    .rdata_i   (bus_rdata_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .req_o     (bus_req_o),
    .we_o      (bus_we_o),
    .addr_o    (bus_addr_o),
    .be_o      (bus_be_o),
    .wdata_o   (bus_wdata_o),
    .data_o    (data_o)
  );

  always_comb begin
    rd_cycles_o    = plan_rd_q.cycles;
    wr_cycles_o    = plan_wr_q.cycles;
    total_cycles_o = total_q;
  end

endmodule

// File: rtl/dma_unit_seq_chk.sv
module dma_unit_seq_chk #(
  parameter int AW    = 16,
  parameter int CW    = 4,
  parameter int TOT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             bus_req_o,
  input logic             bus_we_o,
  input logic             bus_ready_i,
  input logic [AW-1:0]    bus_addr_o,
  input logic [1:0]       bus_be_o,
  input logic [2:0]       rd_cycles_o,
  input logic [2:0]       wr_cycles_o,
  input logic [TOT_W-1:0] total_cycles_o
);

  localparam int MAX_TOT = 2 * 4 * ((1 << CW) - 1);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(bus_req_o && bus_we_o));

  a_r1_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> busy_o);

  a_r1_counts_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(total_cycles_o) && $stable(rd_cycles_o) && $stable(wr_cycles_o));

  a_r2_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_be_o == 2'b11) |-> !bus_addr_o[0]);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ready_i) |=> bus_req_o && $stable(bus_addr_o)
                                    && $stable(bus_be_o) && $stable(bus_we_o));

  a_r9_count_shape: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(rd_cycles_o) == 1 && $countones(wr_cycles_o) == 1));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (int'(total_cycles_o) <= MAX_TOT));

endmodule

bind dma_unit_seq dma_unit_seq_chk #(.AW(AW), .CW(CW), .TOT_W(TOT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .bus_req_o      (bus_req_o),
  .bus_we_o       (bus_we_o),
  .bus_ready_i    (bus_ready_i),
  .bus_addr_o     (bus_addr_o),
  .bus_be_o       (bus_be_o),
  .rd_cycles_o    (rd_cycles_o),
  .wr_cycles_o    (wr_cycles_o),
  .total_cycles_o (total_cycles_o)
);

// File: tb/tb_dma_unit_seq.sv
module tb_dma_unit_seq;

  localparam logic [15:0] REG_B = 16'h0100, REG_L = 16'h03FF;
  localparam logic [15:0] WT_B  = 16'hA000, WT_L  = 16'hAFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, unit16_i, bus8_i, bus_ready_i;
  logic [15:0] src_addr_i, dst_addr_i, bus_rdata_i;
  logic [3:0]  coef_rd_i, coef_wr_i;
  logic        busy_o, done_o, bus_req_o, bus_we_o;
  logic [15:0] bus_addr_o, bus_wdata_o, data_o;
  logic [1:0]  bus_be_o;
  logic [2:0]  rd_cycles_o, wr_cycles_o;
  logic [7:0]  total_cycles_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_unit_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .unit16_i(unit16_i), .bus8_i(bus8_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .reg_base_i(REG_B), .reg_limit_i(REG_L), .wait_base_i(WT_B), .wait_limit_i(WT_L),
    .coef_rd_i(coef_rd_i), .coef_wr_i(coef_wr_i),
    .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_be_o(bus_be_o), .bus_wdata_o(bus_wdata_o),
    .data_o(data_o), .rd_cycles_o(rd_cycles_o), .wr_cycles_o(wr_cycles_o),
    .total_cycles_o(total_cycles_o)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic bit in_ext(input logic [15:0] a);
    return (a >= REG_B && a <= REG_L) || (a >= WT_B && a <= WT_L);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive read lanes from the current bus address
  task automatic drive_rdata();
    if (bus8_i)              bus_rdata_i = {8'hEE, mb(bus_addr_o)};
    else if (bus_addr_o[0])  bus_rdata_i = {mb(bus_addr_o), 8'hEE};
    else                     bus_rdata_i = {mb(bus_addr_o + 16'd1), mb(bus_addr_o)};
  endtask

  task automatic run_unit(input logic [15:0] s, input logic [15:0] d, input bit u16,
                          input bit b8, input logic [3:0] cj, input logic [3:0] ck,
                          input int stall_pct, input bit poke);
    int nr, nw, n;
    bit er, ew;
    logic [15:0] exd;
    logic [2:0] rc, wc;
    logic [7:0] tot;
    logic [15:0] ea [4];
    logic [1:0]  ebe [4];
    bit          ewe [4];
    bit          eext [4];
    logic [15:0] ewd [4];
    nr  = (u16 && (b8 || s[0])) ? 2 : 1;
    nw  = (u16 && (b8 || d[0])) ? 2 : 1;
    er  = in_ext(s);
    ew  = in_ext(d);
    rc  = 3'(nr * (er ? 2 : 1));
    wc  = 3'(nw * (ew ? 2 : 1));
    tot = 8'(rc * cj + wc * ck);
    exd = u16 ? {mb(s + 16'd1), mb(s)} : {8'h00, mb(s)};
    n = nr + nw;
    for (int i = 0; i < n; i++) begin
      bit wr;
      int bi;
      logic [15:0] b;
      logic [7:0] byt;
      wr = (i >= nr);
      bi = wr ? i - nr : i;
      b  = wr ? d : s;
      ewe[i]  = wr;
      eext[i] = wr ? ew : er;
      if ((wr ? nw : nr) == 1 && u16) begin
        ea[i] = b; ebe[i] = 2'b11; ewd[i] = exd;
      end else begin
        ea[i]  = b + 16'(bi);
        byt    = bi[0] ? exd[15:8] : exd[7:0];
        if (!b8 && ea[i][0]) begin ebe[i] = 2'b10; ewd[i] = {byt, 8'h00}; end
        else                 begin ebe[i] = 2'b01; ewd[i] = {8'h00, byt}; end
      end
    end

    @(negedge clk);
    src_addr_i = s; dst_addr_i = d; unit16_i = u16; bus8_i = b8;
    coef_rd_i = cj; coef_wr_i = ck; start_i = 1'b1; bus_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1", "busy after start", 32'(busy_o), 1);
    chk(rd_cycles_o == rc, "R9", "read cycles", 32'(rd_cycles_o), 32'(rc));
    chk(wr_cycles_o == wc, "R9", "write cycles", 32'(wr_cycles_o), 32'(wc));
    chk(total_cycles_o == tot, "R10", "total cycles", 32'(total_cycles_o), 32'(tot));

    begin
      int k = 0;
      int pos = 0;
      while (k < n) begin
        string rq;
        bit rdy, comp;
        rq = (ebe[k] == 2'b11) ? "R2" : (u16 ? (b8 ? "R4" : "R3") : "R5");
        chk(bus_req_o && (bus_we_o == ewe[k]), ewe[k] ? "R1" : "R1",
            "phase order / request", {30'd0, bus_req_o, bus_we_o}, {30'd0, 1'b1, ewe[k]});
        chk(bus_addr_o == ea[k] && bus_be_o == ebe[k], rq, "address+lanes",
            {14'd0, bus_be_o, bus_addr_o}, {14'd0, ebe[k], ea[k]});
        if (ewe[k])
          chk(bus_wdata_o == ewd[k], "R8", "write data",
              32'(bus_wdata_o), 32'(ewd[k]));
        rdy = ($urandom % 100) >= stall_pct;
        if (poke && k == 0 && pos == 0) begin
          start_i = 1'b1; src_addr_i = ~s; dst_addr_i = ~d;
          unit16_i = ~u16; coef_rd_i = ~cj;
        end else begin
          start_i = 1'b0;
        end
        bus_ready_i = rdy;
        drive_rdata();
        comp = rdy && (pos >= (eext[k] ? 1 : 0));
        @(negedge clk);
        start_i = 1'b0;
        if (!comp && k < n)
          chk(bus_req_o && bus_addr_o == ea[k] && bus_we_o == ewe[k],
              eext[k] ? "R6" : "R7", "access held", 32'(bus_addr_o), 32'(ea[k]));
        if (comp) begin k++; pos = 0; end
        else pos++;
      end
    end
    bus_ready_i = 1'b0;
    chk(done_o && !busy_o, "R11", "done with busy low", {30'd0, done_o, busy_o}, 32'h2);
    chk(data_o == exd, "R8", "buffer contents", 32'(data_o), 32'(exd));
    chk(total_cycles_o == tot && rd_cycles_o == rc, "R1", "counts unchanged by busy start",
        32'(total_cycles_o), 32'(tot));
    @(negedge clk);
    chk(!done_o && !busy_o, "R11", "single done pulse", {30'd0, done_o, busy_o}, 0);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 9)
      0: return REG_B - 16'd1;
      1: return REG_B;
      2: return REG_L;
      3: return REG_L + 16'd1;
      4: return WT_B - 16'd1;
      5: return WT_B + 16'($urandom % 4096);
      6: return WT_L;
      7: return WT_L + 16'd1;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b0; start_i = 1'b0; unit16_i = 1'b0; bus8_i = 1'b0; bus_ready_i = 1'b0;
    src_addr_i = '0; dst_addr_i = '0; coef_rd_i = '0; coef_wr_i = '0; bus_rdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !bus_req_o, "R1", "reset idle",
        {29'd0, busy_o, done_o, bus_req_o}, 0);

    // Directed corners
    run_unit(16'h2000, 16'h3000, 1, 0, 4'd1, 4'd1, 0, 0);   // R2 even word
    run_unit(16'h2001, 16'h3003, 1, 0, 4'd2, 4'd3, 0, 0);   // R3 odd split
    run_unit(16'h2001, 16'h3000, 1, 0, 4'd1, 4'd2, 30, 0);  // R3 mixed
    run_unit(16'h2000, 16'h3001, 1, 1, 4'd1, 4'd1, 0, 0);   // R4 8-bit bus
    run_unit(16'h2003, 16'h3002, 0, 0, 4'd5, 4'd7, 0, 0);   // R5 odd byte
    run_unit(16'h2003, 16'h3005, 0, 1, 4'd2, 4'd2, 0, 0);   // R5 8-bit bus
    run_unit(REG_B, WT_L, 1, 0, 4'd1, 4'd1, 0, 0);          // R6 inclusive bounds
    run_unit(REG_B - 16'd1, WT_L + 16'd1, 1, 0, 4'd1, 4'd1, 0, 0); // R6 just outside
    run_unit(REG_L, WT_B + 16'd1, 1, 1, 4'd15, 4'd15, 0, 0); // R10 worst total 120
    run_unit(16'hFFFF, 16'h0000, 1, 0, 4'd3, 4'd4, 60, 0);  // R7 stalls, wrap
    run_unit(16'h2001, WT_B, 1, 0, 4'd6, 4'd9, 20, 1);      // R1 start while busy

    for (int i = 0; i < 120; i++)
      run_unit(pick_addr(), pick_addr(), bit'($urandom % 2), bit'($urandom % 2),
               4'($urandom), 4'($urandom), int'($urandom % 60), bit'(($urandom % 5) == 0));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule